// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps the books for a small packet memory that is carved into 256-byte pages. A host issues eight-bit command words. Each command can do one of the following:

- claim pages for a new outgoing packet;
- put a packet on the transmit queue;
- drop or free the packet at the head of the receive queue;
- free a packet by number;
- clear the transmit queue;
- return the whole allocator to its empty state.

Each packet gets a small identifier from a pool of eight. The identifier goes back to the pool only when the packet's pages are freed.

The receive path of the MAC pushes completed packet numbers into the receive queue. The transmit path pops the head of the transmit queue once it has finished with that packet. The host sees four things:

- an allocation result byte;
- a one-cycle allocation-done event;
- a busy flag that covers a release in progress;
- two status words: the queue heads with their empty flags, and the free and total page counts.

Top module: `page_alloc`

## Requirements
- R1: After reset the block shows the following. queueHeads reads 16'h8080: both empty flags are set and both head fields are 0. memInfo reads free pages equal to total pages. allocResult reads 8'h80. busy and allocDone are 0.
- R2: An accepted command with cmdWord[7:5]=1 asks for cmdWord[4:0]+1 pages. On success, allocResult reads the lowest unused identifier (bit 7 clear) from the next cycle. allocDone pulses for that one cycle, and the free page count drops by the request.
- R3: An allocation fails, with no partial grant, in two cases: free pages are fewer than txReserve plus the request, or all eight identifiers are in use. On failure allocResult reads 8'h80, the free count is unchanged and allocDone stays 0.
- R4: Opcode 5 frees the packet named on pktNum. Its pages return to the free count and its identifier becomes available again. Freeing an identifier that is not allocated changes nothing.
- R5: Opcode 6 appends pktNum to the transmit queue in arrival order. queueHeads[6:0] holds the transmit head and bit 7 is set when that queue is empty. An empty queue reads head 0.
- R6: txDonePop removes the transmit head. A pop on an empty queue is ignored.
- R7: rxPush appends rxPushPkt to the receive queue. queueHeads[14:8] holds the receive head and bit 15 is set when that queue is empty.
- R8: Opcode 3 removes the receive head and leaves its pages allocated.
- R9: Opcode 4 removes the receive head and raises busy for the next cycle. The head's pages are returned when busy falls. A command that arrives while busy is high is ignored.
- R10: Opcode 7 empties the transmit queue. It does not touch the receive queue or any allocation.
- R11: Opcode 2 frees every packet, empties both queues and sets allocResult to 8'h80.
- R12: A push and a pop that hit the same non-empty queue in one cycle both take effect. On an empty queue the push still lands.
- R13: memInfo[15:8] is the free page count, memInfo[7:0] is the total page count, and free never exceeds total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command word present this cycle |
| cmdWord | input | 8 | Opcode in bits 7:5, page request minus one in bits 4:0 |
| pktNum | input | 3 | Packet number used by free and enqueue |
| txReserve | input | 5 | Pages held back from allocation |
| rxPush | input | 1 | Receive path appends a packet |
| rxPushPkt | input | 3 | Packet number being appended to the receive queue |
| txDonePop | input | 1 | Transmit path retires the transmit head |
| allocResult | output | 8 | Allocated identifier, or 8'h80 on failure |
| allocDone | output | 1 | One-cycle pulse on a successful allocation |
| busy | output | 1 | Release in progress |
| queueHeads | output | 16 | Receive head and empty flag, transmit head and empty flag |
| memInfo | output | 16 | Free pages (high byte), total pages (low byte) |

## Verification
Each queue can see a push and a pop in the same cycle, and the bench provokes both cases on purpose:

- Transmit queue: enqueue and txDonePop are driven together, with a single entry queued.
- Receive queue: a release command is issued in the same cycle as rxPush.

In both cases the expected head and empty flag come from a reference queue that pops the old head before appending the new entry. A command is also sent during the busy cycle of a release. It must leave the allocation result and the free count exactly as the release alone would.

// File: rtl/page_alloc_pkg.sv
package page_alloc_pkg;
  localparam int ID_W     = 3;
  localparam int NUM_IDS  = 1 << ID_W;
  localparam int REQ_W    = 5;
  localparam int PG_W     = REQ_W + 1;
  localparam int HEAD_W   = 7;

  typedef enum logic [2:0] {
    OP_NOP, OP_ALLOC, OP_RESET, OP_REMOVE,
    OP_RELEASE, OP_FREE, OP_ENQUEUE, OP_TXFLUSH
  } opcode_e;

  typedef struct packed {
    logic            alloc;
    logic [PG_W-1:0] allocPages;
    logic            free;
    logic [ID_W-1:0] freeId;
    logic            enqueue;
    logic [ID_W-1:0] enqId;
    logic            rxPop;
    logic            txFlush;
    logic            resetAll;
  } strobes_t;
endpackage

// File: rtl/pa_fifo.sv
module pa_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             popOk, pushOk;

  assign popOk  = pop && (count != '0);
  assign pushOk = push && ((count != CNT_W'(DEPTH)) || popOk);
  assign empty  = (count == '0);
  assign head   = empty ? '0 : store[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (popOk)  rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
    end
  end

  // R12
  fifo_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R12
  fifo_balance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && !empty && !flush) |=> (count == $past(count)));
endmodule

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import page_alloc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [7:0]      cmdWord,
  input  logic [ID_W-1:0] pktSel,
  input  logic [ID_W-1:0] rxHeadId,
  input  logic            rxEmpty,
  output strobes_t        strobes,
  output logic            busy
);
  opcode_e         op;
  logic [ID_W-1:0] relId;

  assign op = opcode_e'(cmdWord[7:5]);

  always_comb begin
    strobes = '0;
    if (busy) begin
      strobes.free   = 1'b1;
      strobes.freeId = relId;
    end else if (cmdValid) begin
      unique case (op)
        OP_ALLOC: begin
          strobes.alloc      = 1'b1;
          strobes.allocPages = {1'b0, cmdWord[REQ_W-1:0]} + 1'b1;
        end
        OP_RESET:               strobes.resetAll = 1'b1;
        OP_REMOVE, OP_RELEASE:  strobes.rxPop    = 1'b1;
        OP_FREE: begin
          strobes.free   = 1'b1;
          strobes.freeId = pktSel;
        end
        OP_ENQUEUE: begin
          strobes.enqueue = 1'b1;
          strobes.enqId   = pktSel;
        end
        OP_TXFLUSH:             strobes.txFlush  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      relId <= '0;
    end else if (busy) begin
      busy  <= 1'b0;
    end else if (cmdValid && op == OP_RELEASE && !rxEmpty) begin
      busy  <= 1'b1;
      relId <= rxHeadId;
    end
  end

  // R9
  busy_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import page_alloc_pkg::*;
#(
  parameter int TOTAL_PAGES = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strobes,
  input  logic [4:0]      txReserve,
  input  logic            rxPush,
  input  logic [ID_W-1:0] rxPushId,
  input  logic            txPop,
  output logic [7:0]      allocResult,
  output logic            allocDone,
  output logic [7:0]      freePages,
  output logic [ID_W-1:0] txHead,
  output logic            txEmpty,
  output logic [ID_W-1:0] rxHead,
  output logic            rxEmpty
);
  localparam logic [7:0] TOTAL = 8'(TOTAL_PAGES);
  localparam logic [7:0] FAIL_CODE = 8'h80;

  logic [NUM_IDS-1:0] used;
  logic [PG_W-1:0]    pageCnt [NUM_IDS];
  logic               hasId, grant, freeOk;
  logic [ID_W-1:0]    pick;
  logic [8:0]         need;

  always_comb begin
    hasId = 1'b0;
    pick  = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (!used[i]) begin
        hasId = 1'b1;
        pick  = ID_W'(i);
      end
    end
  end

  assign need   = {4'b0, txReserve} + {{(9-PG_W){1'b0}}, strobes.allocPages};
  assign grant  = strobes.alloc && hasId && ({1'b0, freePages} >= need);
  assign freeOk = strobes.free && used[strobes.freeId];

  always_ff @(posedge clk) begin
    if (!rstN || strobes.resetAll) begin
      used        <= '0;
      freePages   <= TOTAL;
      allocResult <= FAIL_CODE;
      allocDone   <= 1'b0;
      for (int i = 0; i < NUM_IDS; i++) pageCnt[i] <= '0;
    end else begin
      allocDone <= grant;
      if (strobes.alloc)
        allocResult <= grant ? {{(8-ID_W){1'b0}}, pick} : FAIL_CODE;
      if (grant) begin
        used[pick]    <= 1'b1;
        pageCnt[pick] <= strobes.allocPages;
      end
      if (freeOk) used[strobes.freeId] <= 1'b0;
      freePages <= freePages
                 - (grant  ? 8'(strobes.allocPages)          : 8'd0)
                 + (freeOk ? 8'(pageCnt[strobes.freeId])     : 8'd0);
    end
  end

  pa_fifo #(.DEPTH(NUM_IDS), .W(ID_W)) i_txq (
    .clk(clk), .rstN(rstN),
    .flush(strobes.txFlush || strobes.resetAll),
    .push(strobes.enqueue), .pushData(strobes.enqId),
    .pop(txPop), .head(txHead), .empty(txEmpty)
  );

  pa_fifo #(.DEPTH(NUM_IDS), .W(ID_W)) i_rxq (
    .clk(clk), .rstN(rstN),
    .flush(strobes.resetAll),
    .push(rxPush), .pushData(rxPushId),
    .pop(strobes.rxPop), .head(rxHead), .empty(rxEmpty)
  );

  // R13
  free_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    freePages <= TOTAL);

  // R2
  done_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocDone |-> !allocResult[7]);

  // R3
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.alloc |=> (allocResult[7] == (freePages == $past(freePages))));
endmodule

// File: rtl/page_alloc.sv
module page_alloc
  import page_alloc_pkg::*;
#(
  parameter int TOTAL_PAGES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [7:0]       cmdWord,
  input  logic [ID_W-1:0]  pktNum,
  input  logic [4:0]       txReserve,
  input  logic             rxPush,
  input  logic [ID_W-1:0]  rxPushPkt,
  input  logic             txDonePop,
  output logic [7:0]       allocResult,
  output logic             allocDone,
  output logic             busy,
  output logic [15:0]      queueHeads,
  output logic [15:0]      memInfo
);
  strobes_t        strobes;
  logic [7:0]      freePages;
  logic [ID_W-1:0] txHead, rxHead;
  logic            txEmpty, rxEmpty;

  pa_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .pktSel(pktNum), .rxHeadId(rxHead), .rxEmpty(rxEmpty),
    .strobes(strobes), .busy(busy)
  );

  pa_datapath #(.TOTAL_PAGES(TOTAL_PAGES)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txReserve(txReserve),
    .rxPush(rxPush), .rxPushId(rxPushPkt), .txPop(txDonePop),
    .allocResult(allocResult), .allocDone(allocDone), .freePages(freePages),
    .txHead(txHead), .txEmpty(txEmpty), .rxHead(rxHead), .rxEmpty(rxEmpty)
  );

  assign queueHeads = {rxEmpty, {(HEAD_W-ID_W){1'b0}}, rxHead,
                       txEmpty, {(HEAD_W-ID_W){1'b0}}, txHead};
  assign memInfo    = {freePages, 8'(TOTAL_PAGES)};
endmodule

// File: tb/test_page_alloc.sv
`timescale 1ns/1ps
module test_page_alloc;
  localparam int TOTAL = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdWord = '0;
  logic [2:0] pktNum = '0;
  logic [4:0] txReserve = '0;
  logic       rxPush = 1'b0;
  logic [2:0] rxPushPkt = '0;
  logic       txDonePop = 1'b0;
  logic [7:0] allocResult;
  logic       allocDone, busy;
  logic [15:0] queueHeads, memInfo;

  always #2 clk = ~clk;

  page_alloc #(.TOTAL_PAGES(TOTAL)) i_page_alloc (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .pktNum(pktNum), .txReserve(txReserve), .rxPush(rxPush),
    .rxPushPkt(rxPushPkt), .txDonePop(txDonePop), .allocResult(allocResult),
    .allocDone(allocDone), .busy(busy), .queueHeads(queueHeads), .memInfo(memInfo)
  );

  typedef struct {
    string       tag;
    logic [15:0] heads;
    logic [15:0] mem;
    logic [7:0]  res;
    logic        done;
    logic        bsy;
  } exp_t;

  exp_t expQ[$];
  int vectors = 0, errors = 0;
  bit finished = 0;

  // reference model
  int   freeM = TOTAL;
  bit   usedM [8];
  int   pagesM [8];
  int   txQ[$], rxQ[$];
  logic [7:0] resM = 8'h80;
  bit   doneM = 0, busyM = 0;
  int   relM = 0;

  function automatic logic [15:0] headsM();
    logic [15:0] h;
    h[15]   = (rxQ.size() == 0);
    h[14:8] = (rxQ.size() == 0) ? 7'd0 : 7'(rxQ[0]);
    h[7]    = (txQ.size() == 0);
    h[6:0]  = (txQ.size() == 0) ? 7'd0 : 7'(txQ[0]);
    return h;
  endfunction

  task automatic step(input string tag, input bit cv, input logic [7:0] cw,
                      input logic [2:0] pn, input bit rp, input logic [2:0] rpk,
                      input bit tp);
    exp_t e;
    @(negedge clk);
    cmdValid = cv; cmdWord = cw; pktNum = pn;
    rxPush = rp; rxPushPkt = rpk; txDonePop = tp;
    @(posedge clk);
    #1;
    doneM = 0;
    if (tp && txQ.size() > 0) void'(txQ.pop_front());
    if (busyM) begin
      if (usedM[relM]) begin freeM += pagesM[relM]; usedM[relM] = 0; end
      busyM = 0;
    end else if (cv) begin
      case (cw[7:5])
        3'd1: begin
          int n, id;
          n = int'(cw[4:0]) + 1;
          id = -1;
          for (int i = 7; i >= 0; i--) if (!usedM[i]) id = i;
          if (id >= 0 && freeM >= int'(txReserve) + n) begin
            usedM[id] = 1; pagesM[id] = n; freeM -= n;
            resM = 8'(id); doneM = 1;
          end else resM = 8'h80;
        end
        3'd2: begin
          for (int i = 0; i < 8; i++) usedM[i] = 0;
          freeM = TOTAL; txQ.delete(); rxQ.delete(); resM = 8'h80;
        end
        3'd3: if (rxQ.size() > 0) void'(rxQ.pop_front());
        3'd4: if (rxQ.size() > 0) begin relM = rxQ.pop_front(); busyM = 1; end
        3'd5: if (usedM[pn]) begin freeM += pagesM[pn]; usedM[pn] = 0; end
        3'd6: if (txQ.size() < 8) txQ.push_back(int'(pn));
        3'd7: txQ.delete();
        default: ;
      endcase
    end
    if (rp && rxQ.size() < 8) rxQ.push_back(int'(rpk));
    e.tag = tag; e.heads = headsM(); e.mem = {8'(freeM), 8'(TOTAL)};
    e.res = resM; e.done = doneM; e.bsy = busyM;
    expQ.push_back(e);
  endtask

  task automatic cmd(input string tag, input logic [7:0] cw, input logic [2:0] pn);
    step(tag, 1'b1, cw, pn, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 8'h00, 3'd0, 1'b0, 3'd0, 1'b0);
  endtask

  // monitor: compare design outputs against expected items
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      vectors++;
      if (queueHeads !== e.heads || memInfo !== e.mem || allocResult !== e.res ||
          allocDone !== e.done || busy !== e.bsy) begin
        errors++;
        $display("FAIL %s: heads=%h mem=%h res=%h done=%b busy=%b expected heads=%h mem=%h res=%h done=%b busy=%b",
                 e.tag, queueHeads, memInfo, allocResult, allocDone, busy,
                 e.heads, e.mem, e.res, e.done, e.bsy);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle("R1 reset state");
    cmd("R2 alloc 4 pages", 8'h23, 3'd0);
    cmd("R2 alloc 8 pages", 8'h27, 3'd0);
    cmd("R3 alloc 5 with 4 free", 8'h24, 3'd0);
    txReserve = 5'd2;
    cmd("R3 reserve blocks alloc", 8'h22, 3'd0);
    cmd("R2 alloc exactly fits reserve", 8'h21, 3'd0);
    txReserve = 5'd0;
    cmd("R4 free id1", 8'hA0, 3'd1);
    cmd("R4 free unallocated id1", 8'hA0, 3'd1);
    cmd("R2 lowest id reused", 8'h20, 3'd0);
    cmd("R5 enqueue 2", 8'hC0, 3'd2);
    cmd("R5 enqueue 0 keeps order", 8'hC0, 3'd0);
    step("R6 tx pop", 1'b0, 8'h00, 3'd0, 1'b0, 3'd0, 1'b1);
    step("R12 tx pop and enqueue", 1'b1, 8'hC0, 3'd1, 1'b0, 3'd0, 1'b1);
    step("R6 tx pop to empty", 1'b0, 8'h00, 3'd0, 1'b0, 3'd0, 1'b1);
    step("R6 pop on empty ignored", 1'b0, 8'h00, 3'd0, 1'b0, 3'd0, 1'b1);
    step("R12 enqueue and pop on empty", 1'b1, 8'hC0, 3'd1, 1'b0, 3'd0, 1'b1);
    step("R7 rx push 2", 1'b0, 8'h00, 3'd0, 1'b1, 3'd2, 1'b0);
    step("R7 rx push 1", 1'b0, 8'h00, 3'd0, 1'b1, 3'd1, 1'b0);
    cmd("R8 remove keeps pages", 8'h60, 3'd0);
    step("R9 R12 release with rx push", 1'b1, 8'h80, 3'd0, 1'b1, 3'd0, 1'b0);
    cmd("R9 command ignored while busy", 8'h20, 3'd0);
    idle("R9 after release");
    cmd("R10 tx flush", 8'hE0, 3'd0);
    cmd("R11 reset allocator", 8'h40, 3'd0);
    for (int k = 0; k < 8; k++) cmd("R2 fill identifiers", 8'h20, 3'd0);
    cmd("R3 no identifier left", 8'h20, 3'd0);
    cmd("R13 free id7", 8'hA0, 3'd7);
    idle("R13 memInfo steady");
    @(negedge clk);
    cmdValid = 1'b0; rxPush = 1'b0; txDonePop = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule